// File: doc/BRIEF.md
# Processor Presence Bitmap

This block keeps a presence map with one bit per processor ID. The bit for ID n sits in byte n/8, at bit position n%8. At reset the map loads a presence vector that describes the processors present at start-up. After reset the map changes only through plug and unplug events. Each event carries a processor ID and updates exactly one bit.

Every accepted event also raises a one-cycle mask that sets the processor-hotplug bit of the general-purpose event status register. The interrupt logic that sits downstream then re-evaluates its request.

Software reads the map one byte at a time through a byte-wide window. The byte offset selects which byte is returned. Writes to the window are taken and discarded. An event whose ID is outside the map is dropped without any trace.

Top module: `cpu_presence_map`

## Requirements
- R1: Processor ID n is held in bit n%8 of byte n/8, and a window read at byte offset k returns bits 8k+7..8k of the map, with ID 8k in bit 0.
- R2: While rst_n is low, the map takes the value of init_present, and rd_data and gpe_set are 0.
- R3: A valid event with evt_plug=1 and an ID below NUM_CPUS sets that ID's bit in the next cycle.
- R4: A valid event with evt_plug=0 and an ID below NUM_CPUS clears that ID's bit in the next cycle. All other bits are left unchanged.
- R5: In the cycle after each in-range valid event, gpe_set equals 8'h04 (only bit 2 set) for exactly one cycle. In every other cycle gpe_set is 0.
- R6: A valid event with an ID of NUM_CPUS or above changes no map bit and leaves gpe_set at 0.
- R7: A read (rd_en=1) loads rd_data with the addressed byte one cycle later. Without a read, rd_data holds its value.
- R8: A window write (wr_en=1) changes neither the map nor rd_data.
- R9: When a read and an event occur in the same cycle, the read returns the byte value from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_present | input | NUM_CPUS | Presence vector loaded during reset |
| evt_valid | input | 1 | Event strobe |
| evt_plug | input | 1 | 1 = plug, 0 = unplug |
| evt_id | input | EVT_ID_W | Processor ID of the event |
| rd_en | input | 1 | Window read strobe |
| wr_en | input | 1 | Window write strobe (ignored) |
| addr | input | ADDR_W | Byte offset within the window |
| wr_data | input | 8 | Write data (ignored) |
| rd_data | output | 8 | Registered read byte |
| gpe_set | output | 8 | One-cycle status-set mask |

## Verification
The bench targets the corner cases of this block.

- **Map ends.** It uses IDs 0 and NUM_CPUS-1. A design with the wrong byte or bit index would return the bit in a neighbouring byte or in a mirrored position.
- **Out-of-range IDs.** It sends IDs 256 and 511. A design that truncated the ID would instead flip bit 0 or bit 255 and pulse the status mask.
- **Read and event in the same cycle.** It issues both together on one byte. A design that bypassed the update into the read would return the new byte instead of the old one.
- **Window writes.** It writes the window and then reads the map back. Any leak from the write path would show up as a changed byte.

// File: rtl/cpu_presence_pkg.sv
package cpu_presence_pkg;
   localparam int unsigned BYTE_W = 8;

   typedef enum logic {
      EVT_UNPLUG = 1'b0,
      EVT_PLUG   = 1'b1
   } evt_kind_e;

   typedef struct packed {
      logic      hit;
      evt_kind_e kind;
   } evt_ctl_t;
endpackage

// File: rtl/cpu_evt_decode.sv
module cpu_evt_decode #(
   parameter int unsigned NUM_CPUS = 256,
   parameter int unsigned EVT_ID_W = 9,
   localparam int unsigned NBYTES  = NUM_CPUS / 8,
   localparam int unsigned BSEL_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
   input  logic                               evt_valid,
   input  logic                               evt_plug,
   input  logic [EVT_ID_W-1:0]                evt_id,
   output cpu_presence_pkg::evt_ctl_t         ctl,
   output logic [NBYTES-1:0]                  byte_sel,
   output logic [cpu_presence_pkg::BYTE_W-1:0] bit_mask
);
   import cpu_presence_pkg::*;

   logic              in_range;
   logic [BSEL_W-1:0] byte_idx;
   logic [2:0]        bit_idx;

   assign in_range = ({1'b0, evt_id} < (EVT_ID_W+1)'(NUM_CPUS));
   assign bit_idx  = evt_id[2:0];

   generate
      if (NBYTES > 1) begin : g_multi
         assign byte_idx = evt_id[BSEL_W+2:3];
      end else begin : g_single
         assign byte_idx = '0;
      end
   endgenerate

   assign ctl.hit  = evt_valid & in_range;
   assign ctl.kind = evt_plug ? EVT_PLUG : EVT_UNPLUG;

   always_comb begin
      byte_sel = '0;
      bit_mask = '0;
      if (ctl.hit) begin
         byte_sel[byte_idx] = 1'b1;
         bit_mask[bit_idx]  = 1'b1;
      end
   end
endmodule

// File: rtl/cpu_map_store.sv
module cpu_map_store #(
   parameter int unsigned NUM_CPUS = 256,
   localparam int unsigned NBYTES  = NUM_CPUS / 8
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [NUM_CPUS-1:0]                 init_present,
   input  cpu_presence_pkg::evt_ctl_t          ctl,
   input  logic [NBYTES-1:0]                   byte_sel,
   input  logic [cpu_presence_pkg::BYTE_W-1:0] bit_mask,
   output logic [NUM_CPUS-1:0]                 map_q
);
   import cpu_presence_pkg::*;

   for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      logic [BYTE_W-1:0] cur;
      assign cur = map_q[b*BYTE_W +: BYTE_W];
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            map_q[b*BYTE_W +: BYTE_W] <= init_present[b*BYTE_W +: BYTE_W];
         end else if (byte_sel[b]) begin
            if (ctl.kind == EVT_PLUG)
               map_q[b*BYTE_W +: BYTE_W] <= cur | bit_mask;
            else
               map_q[b*BYTE_W +: BYTE_W] <= cur & ~bit_mask;
         end
      end
   end
endmodule

// File: rtl/cpu_byte_reader.sv
module cpu_byte_reader #(
   parameter int unsigned NUM_CPUS = 256,
   localparam int unsigned NBYTES  = NUM_CPUS / 8,
   localparam int unsigned ADDR_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [NUM_CPUS-1:0]                 map_q,
   input  logic                                rd_en,
   input  logic [ADDR_W-1:0]                   addr,
   output logic [cpu_presence_pkg::BYTE_W-1:0] rd_data
);
   import cpu_presence_pkg::*;

   logic [BYTE_W-1:0] sel_byte;

   always_comb begin
      sel_byte = '0;
      for (int i = 0; i < NBYTES; i++) begin
         if (ADDR_W'(i) == addr) sel_byte = map_q[i*BYTE_W +: BYTE_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= sel_byte;
   end
endmodule

// File: rtl/cpu_presence_map.sv
module cpu_presence_map #(
   parameter int unsigned NUM_CPUS = 256,
   parameter int unsigned EVT_ID_W = 9,
   parameter int unsigned GPE_BIT  = 2,
   localparam int unsigned NBYTES  = NUM_CPUS / 8,
   localparam int unsigned ADDR_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_CPUS-1:0] init_present,
   input  logic                evt_valid,
   input  logic                evt_plug,
   input  logic [EVT_ID_W-1:0] evt_id,
   input  logic                rd_en,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [7:0]          wr_data,
   output logic [7:0]          rd_data,
   output logic [7:0]          gpe_set
);
   import cpu_presence_pkg::*;

   generate
      if (NUM_CPUS % 8 != 0 || NUM_CPUS < 8) begin : g_bad_cpus
         $error("NUM_CPUS must be a nonzero multiple of 8");
      end
      if ((2 ** EVT_ID_W) < NUM_CPUS) begin : g_bad_idw
         $error("EVT_ID_W too narrow for NUM_CPUS");
      end
      if (GPE_BIT > 7) begin : g_bad_gpe
         $error("GPE_BIT must select a bit of a byte");
      end
   endgenerate

   evt_ctl_t           ctl;
   logic [NBYTES-1:0]  byte_sel;
   logic [BYTE_W-1:0]  bit_mask;
   logic [NUM_CPUS-1:0] cpu_map;
   logic               wr_unused;

   // Window writes are accepted and dropped.
   assign wr_unused = wr_en & (|wr_data);

   cpu_evt_decode #(.NUM_CPUS(NUM_CPUS), .EVT_ID_W(EVT_ID_W)) u_dec (
      .evt_valid (evt_valid),
      .evt_plug  (evt_plug),
      .evt_id    (evt_id),
      .ctl       (ctl),
      .byte_sel  (byte_sel),
      .bit_mask  (bit_mask)
   );

   cpu_map_store #(.NUM_CPUS(NUM_CPUS)) u_store (
      .clk          (clk),
      .rst_n        (rst_n),
      .init_present (init_present),
      .ctl          (ctl),
      .byte_sel     (byte_sel),
      .bit_mask     (bit_mask),
      .map_q        (cpu_map)
   );

   cpu_byte_reader #(.NUM_CPUS(NUM_CPUS)) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .map_q   (cpu_map),
      .rd_en   (rd_en),
      .addr    (addr),
      .rd_data (rd_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)       gpe_set <= '0;
      else if (ctl.hit) gpe_set <= 8'(1) << GPE_BIT;
      else              gpe_set <= '0;
   end
endmodule

// File: rtl/cpu_presence_map_chk.sv
module cpu_presence_map_chk #(
   parameter int unsigned NUM_CPUS = 256,
   parameter int unsigned EVT_ID_W = 9,
   parameter int unsigned GPE_BIT  = 2,
   localparam int unsigned NBYTES  = NUM_CPUS / 8,
   localparam int unsigned ADDR_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1,
   localparam int unsigned IDX_W   = $clog2(NUM_CPUS)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                evt_valid,
   input logic                evt_plug,
   input logic [EVT_ID_W-1:0] evt_id,
   input logic                rd_en,
   input logic                wr_en,
   input logic [ADDR_W-1:0]   addr,
   input logic [7:0]          rd_data,
   input logic [7:0]          gpe_set,
   input logic [NUM_CPUS-1:0] cpu_map
);
   logic in_rng;
   assign in_rng = evt_valid && ({1'b0, evt_id} < (EVT_ID_W+1)'(NUM_CPUS));

   // R3
   plug_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_rng && evt_plug |=> cpu_map[$past(evt_id[IDX_W-1:0])]);

   // R4
   unplug_clears_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_rng && !evt_plug |=> !cpu_map[$past(evt_id[IDX_W-1:0])]);

   // R5
   gpe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_rng |=> gpe_set == (8'(1) << GPE_BIT));

   // R6
   no_stray_gpe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_rng |=> gpe_set == 8'h00);

   // R6
   out_of_range_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_rng |=> $stable(cpu_map));

   // R7
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));

   // R9
   rd_old_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_data == $past(cpu_map[addr*8 +: 8]));
endmodule

bind cpu_presence_map cpu_presence_map_chk #(
   .NUM_CPUS(NUM_CPUS), .EVT_ID_W(EVT_ID_W), .GPE_BIT(GPE_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_plug(evt_plug),
   .evt_id(evt_id), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
   .rd_data(rd_data), .gpe_set(gpe_set), .cpu_map(cpu_map)
);

// File: tb/sim_cpu_presence_map.sv
module sim_cpu_presence_map;
   localparam int CLK_PERIOD = 10;
   localparam int NCPU = 256;

   logic            clk = 0;
   logic            rst_n = 0;
   logic [NCPU-1:0] init_present;
   logic            evt_valid = 0, evt_plug = 0;
   logic [8:0]      evt_id = '0;
   logic            rd_en = 0, wr_en = 0;
   logic [4:0]      addr = '0;
   logic [7:0]      wr_data = '0;
   logic [7:0]      rd_data, gpe_set;

   bit [NCPU-1:0]   model;
   int checks = 0, fails = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cpu_presence_map u0 (
      .clk(clk), .rst_n(rst_n), .init_present(init_present),
      .evt_valid(evt_valid), .evt_plug(evt_plug), .evt_id(evt_id),
      .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
      .rd_data(rd_data), .gpe_set(gpe_set)
   );

   function automatic logic [7:0] exp_byte(input int k);
      return model[k*8 +: 8];
   endfunction

   function automatic logic [7:0] exp_gpe(input logic v, input int id);
      return (v && id < NCPU) ? 8'h04 : 8'h00;
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   // One cycle: optional event, read and write; checks read data and gpe mask.
   task automatic cycle(input logic ev, input logic plug, input int id,
                        input logic rd, input int a, input logic wr,
                        input string req);
      logic [7:0] exp_rd, exp_g;
      @(negedge clk);
      evt_valid = ev; evt_plug = plug; evt_id = 9'(id);
      rd_en = rd; addr = 5'(a); wr_en = wr; wr_data = wr ? 8'(  $urandom) : 8'h00;
      exp_rd = rd ? exp_byte(a) : rd_data;   // pre-update byte (R9)
      exp_g  = exp_gpe(ev, id);
      if (ev && id < NCPU) model[id] = plug;
      @(posedge clk); #1;
      chk({req, " rd"}, rd_data, exp_rd);
      chk({req, " gpe"}, gpe_set, exp_g);
      evt_valid = 0; rd_en = 0; wr_en = 0;
   endtask

   task automatic read_all(input string req);
      for (int k = 0; k < NCPU/8; k++) cycle(0, 0, 0, 1, k, 0, req);
   endtask

   initial begin
      process::self().srandom(32'h5eed);
      init_present = {$urandom, $urandom, $urandom, $urandom,
                      $urandom, $urandom, $urandom, $urandom};
      model = init_present;
      repeat (3) @(posedge clk);
      #1;
      // R2: reset state
      chk("R2 rd reset", rd_data, 8'h00);
      chk("R2 gpe reset", gpe_set, 8'h00);
      @(negedge clk); rst_n = 1;
      // R1 R2: initial map readback by byte offset
      read_all("R1_R2 init");
      // R3 R1: plug ends of the map
      cycle(1, 0, 0, 0, 0, 0, "R4 id0 clear");
      cycle(1, 1, 0, 0, 0, 0, "R3 id0 plug");
      cycle(0, 0, 0, 1, 0, 0, "R1 byte0");
      cycle(1, 1, 255, 0, 0, 0, "R3 id255 plug");
      cycle(1, 0, 254, 0, 0, 0, "R4 id254 unplug");
      cycle(0, 0, 0, 1, 31, 0, "R1 byte31");
      // R6: out-of-range IDs
      cycle(1, 1, 256, 0, 0, 0, "R6 id256");
      cycle(1, 0, 511, 0, 0, 0, "R6 id511");
      cycle(1, 1, 300, 0, 0, 0, "R6 id300");
      read_all("R6 map");
      // R9: read and event same byte, same cycle
      cycle(1, ~model[17], 17, 1, 2, 0, "R9 same cycle");
      cycle(0, 0, 0, 1, 2, 0, "R9 after");
      // R7: hold without read
      cycle(1, 1, 40, 0, 5, 0, "R7 hold");
      cycle(0, 0, 0, 0, 5, 0, "R7 hold2");
      // R8: writes ignored
      for (int k = 0; k < 32; k++) cycle(0, 0, 0, 0, k, 1, "R8 write");
      read_all("R8 map");
      // R5: back-to-back events, then idle
      cycle(1, 1, 8, 0, 0, 0, "R5 b2b1");
      cycle(1, 0, 9, 0, 0, 0, "R5 b2b2");
      cycle(0, 0, 0, 0, 0, 0, "R5 idle");
      // Random mix (R3 R4 R5 R6 R7 R8 R9)
      for (int n = 0; n < 2000; n++) begin
         cycle(($urandom % 3) != 0, 1'($urandom), int'($urandom % 300),
               1'($urandom), int'($urandom % 32), 1'($urandom), "RND R3_R4_R5_R7");
      end
      read_all("R1 final");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule